// File: doc/BRIEF.md
# Convert-Framed Serial ADC Reader

This block is the host side of a three-wire link to a 16-bit sampling converter. The three wires are a convert strobe driven by the block, a serial clock driven by the block, and a serial data line driven by the converter. When the block sees a start request, it raises the strobe to launch a conversion. It keeps the strobe high for a programmable number of system clocks, which covers the converter's conversion time. It then drops the strobe, which returns the converter to sampling and opens its data output.

In the read window the block issues 16 serial clock pulses and captures one bit on each rising edge, most significant bit first. The finished word appears on a parallel output together with a one-cycle valid pulse. A parameter sets the serial clock half-period as a whole number of system clocks.

When the read ends, the strobe goes high again. The converter either starts its next conversion or falls asleep once that conversion is done. A later start request therefore reads the conversion that was launched by this edge.

The controller is a three-state machine:
- `ST_IDLE`: not busy. The strobe is low after reset and high after any read.
- `ST_CONVERT`: the strobe is high and the conversion timer runs.
- `ST_READ`: the strobe is low and the serial clock toggles.

It has three transitions:
- `ST_IDLE` to `ST_CONVERT`, when a start request is seen.
- `ST_CONVERT` to `ST_READ`, when the timer expires.
- `ST_READ` to `ST_IDLE`, on the falling serial-clock edge that follows the 16th captured bit.

Top module: `adc_conv_reader`

## Requirements
- R1: While reset is held and after its release, `conv_o`, `sclk_o`, `busy_o` and `valid_o` are low and `data_o` is zero.
- R2: When `start_i` is high in a clock where `busy_o` is low, `conv_o` and `busy_o` are high from the next clock on. While `busy_o` is high, `conv_o` stays high for exactly max(`conv_cycles_i`, 1) clocks, where `conv_cycles_i` is sampled with the start. It then falls.
- R3: `sclk_o` is low whenever `conv_o` is high. After `conv_o` falls, `sclk_o` stays low for SCLK_HALF clocks and then toggles every SCLK_HALF clocks.
- R4: Each read produces exactly 16 rising edges on `sclk_o`.
- R5: `sdo_i` is sampled at the clock edge on which `sclk_o` goes high. The first bit sampled lands in `data_o[15]` and the 16th in `data_o[0]`.
- R6: On the clock edge of the 16th falling `sclk_o` edge, `conv_o` goes high, `busy_o` goes low and `valid_o` is high for exactly one clock. `data_o` then holds the word until the next valid pulse.
- R7: A high `start_i` while `busy_o` is high is ignored. It changes neither the strobe timing nor the number of serial clocks, and it starts nothing after the read ends.
- R8: The word is passed on unchanged as straight binary. The all-zero code and the all-one code both come through intact.
- R9: A `start_i` that is high in the first clock after a valid pulse starts a new transaction at once, even though `conv_o` is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to start a conversion and read |
| conv_cycles_i | input | CONV_W | Strobe high time in system clocks (0 acts as 1) |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Transaction in progress |
| data_o | output | 16 | Last assembled result |
| valid_o | output | 1 | One-cycle pulse when a new word is on `data_o` |

## Verification
A wrong state or a wrong timer value appears on `conv_o` at the clock where the strobe should have fallen. It also stretches or shortens `busy_o`. Either shows up within one clock of the error.

A half-period counter that slips shows up on `sclk_o` at the next toggle point, which is at most SCLK_HALF clocks away. A bit counter or shift register that goes wrong shows up as a missing or extra pulse on `valid_o`, or as a wrong `data_o`. These appear at the end of the same read and are caught there by comparing every clock against a behavioural model of the link.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int unsigned WORD_BITS = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_READ    = 2'd2
    } rd_state_t;

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_q;
    logic [CW:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign expired  = (cnt_next >= {1'b0, lim_q});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt   <= '0;
            lim_q <= limit;
        end else if (!expired) begin
            cnt <= cnt_next[CW-1:0];
        end
    end
endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_now,
    output logic fall_now
);
    localparam int unsigned PH_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

    logic [PH_W-1:0] ph;
    logic            wrap;

    assign wrap     = run && (ph == PH_LAST);
    assign rise_now = wrap && !sclk;
    assign fall_now = wrap && sclk;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            ph   <= '0;
            sclk <= ~sclk;
        end else begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int unsigned BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            take,
    input  logic            din,
    output logic [BITS-1:0] word,
    output logic            full
);
    localparam int unsigned BC_W = $clog2(BITS + 1);
    localparam logic [BC_W-1:0] BC_FULL = BC_W'(BITS);

    logic [BC_W-1:0] bit_cnt;

    assign full = (bit_cnt == BC_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            word    <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (take) begin
            bit_cnt <= bit_cnt + 1'b1;
            word    <= {word[BITS-2:0], din};
        end
    end
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int unsigned BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            conv_done,
    input  logic            finish,
    input  logic [BITS-1:0] word,
    output rd_state_t       state,
    output logic            timer_load,
    output logic            conv_o,
    output logic            busy_o,
    output logic            valid_o,
    output logic [BITS-1:0] data_o
);
    rd_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_i)   nxt = ST_CONVERT;
            ST_CONVERT: if (conv_done) nxt = ST_READ;
            ST_READ:    if (finish)    nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    assign timer_load = (state == ST_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_o  <= 1'b0;
            busy_o  <= 1'b0;
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            busy_o  <= (nxt != ST_IDLE);
            unique case (state)
                ST_IDLE:    if (start_i)   conv_o <= 1'b1;
                ST_CONVERT: if (conv_done) conv_o <= 1'b0;
                ST_READ: begin
                    if (finish) begin
                        conv_o  <= 1'b1;
                        valid_o <= 1'b1;
                        data_o  <= word;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && conv_o));

    // R2
    busy_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> conv_o);
endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned CONV_W    = 16,
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CONV_W-1:0]    conv_cycles_i,
    input  logic                 sdo_i,
    output logic                 conv_o,
    output logic                 sclk_o,
    output logic                 busy_o,
    output logic [WORD_BITS-1:0] data_o,
    output logic                 valid_o
);
    localparam int unsigned HALF_EFF = (SCLK_HALF < 2) ? 2 : SCLK_HALF;

    rd_state_t            state;
    logic                 timer_load;
    logic                 conv_done;
    logic                 rise_now;
    logic                 fall_now;
    logic                 full;
    logic                 finish;
    logic [WORD_BITS-1:0] word;

    assign finish = fall_now && full;

    adc_rd_timer #(.CW(CONV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .limit   (conv_cycles_i),
        .expired (conv_done)
    );

    adc_rd_sclk #(.HALF(HALF_EFF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_READ),
        .sclk     (sclk_o),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    adc_rd_shift #(.BITS(WORD_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_READ),
        .take  (rise_now),
        .din   (sdo_i),
        .word  (word),
        .full  (full)
    );

    adc_rd_fsm #(.BITS(WORD_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .conv_done  (conv_done),
        .finish     (finish),
        .word       (word),
        .state      (state),
        .timer_load (timer_load),
        .conv_o     (conv_o),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .data_o     (data_o)
    );

    // R3
    sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sclk_o);

    // R4
    pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_now |-> !full);

    // R5
    sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (word[0] == $past(sdo_i)));
endmodule

// File: tb/sim_adc_conv_reader.sv
module sim_adc_conv_reader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] conv_cycles_i = '0;
    logic        sdo_i = 1'b0;
    logic        conv_o, sclk_o, busy_o, valid_o;
    logic [15:0] data_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    adc_conv_reader #(.CONV_W(16), .SCLK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_cycles_i(conv_cycles_i),
        .sdo_i(sdo_i), .conv_o(conv_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .data_o(data_o), .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: first bit after strobe falls, next bit on each falling sclk.
    logic [15:0] cv_word = '0;
    int          cv_idx = 0;
    always @(negedge conv_o) begin
        cv_idx = 15;
        sdo_i  = cv_word[15];
    end
    always @(negedge sclk_o) begin
        if (!conv_o) begin
            cv_idx = cv_idx - 1;
            sdo_i  = (cv_idx >= 0) ? cv_word[cv_idx] : 1'b0;
        end
    end

    // Behavioural reference, advanced on every clock edge.
    logic        m_conv = 0, m_sclk = 0, m_busy = 0, m_valid = 0;
    logic [15:0] m_data = '0, m_acc = '0;
    int          m_t = 0, m_n = 1, m_r = 0, m_j = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_conv = 0; m_sclk = 0; m_busy = 0; m_valid = 0; m_data = '0;
        end else begin
            m_valid = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_conv = 1; m_t = 0; m_acc = '0;
                    m_n = (conv_cycles_i == 0) ? 1 : int'(conv_cycles_i);
                end
            end else begin
                m_t = m_t + 1;
                if (m_t == m_n) m_conv = 0;
                else if (m_t > m_n) begin
                    m_r = m_t - m_n;
                    if (m_r % HALF == 0) begin
                        m_j = m_r / HALF;
                        if (m_j % 2 == 1) begin
                            m_sclk = 1;
                            m_acc  = {m_acc[14:0], sdo_i};
                        end else begin
                            m_sclk = 0;
                            if (m_j == 32) begin
                                m_conv = 1; m_busy = 0; m_valid = 1; m_data = m_acc;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic cmp(input string rq, input string nm, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, nm, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the reference (R2 R3 R6 R7).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R2", "conv_o",  {15'd0, conv_o},  {15'd0, m_conv});
            cmp("R3", "sclk_o",  {15'd0, sclk_o},  {15'd0, m_sclk});
            cmp("R7", "busy_o",  {15'd0, busy_o},  {15'd0, m_busy});
            cmp("R6", "valid_o", {15'd0, valid_o}, {15'd0, m_valid});
            cmp("R6", "data_o",  data_o,           m_data);
        end
    end

    int rises = 0, convhi = 0;
    always @(posedge sclk_o) rises++;
    always @(negedge clk) if (busy_o && conv_o) convhi++;

    task automatic wait_valid();
        @(negedge clk);
        while (!valid_o) @(negedge clk);
    endtask

    task automatic run_word(input logic [15:0] w, input logic [15:0] n, input string rq, input bit poke);
        int exp_hi;
        exp_hi = (n == 0) ? 1 : int'(n);
        cv_word = w;
        @(negedge clk);
        start_i = 1; conv_cycles_i = n; rises = 0; convhi = 0;
        @(negedge clk);
        start_i = 0;
        if (poke) begin
            repeat (exp_hi + 4) @(negedge clk);
            start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        wait_valid();
        cmp(rq, "word", data_o, w);
        cmp("R4", "sclk rises", 16'(rises), 16'd16);
        cmp("R2", "strobe high clocks", 16'(convhi), 16'(exp_hi));
        @(negedge clk);
        cmp("R7", "busy after end", {15'd0, busy_o}, 16'd0);
        cmp("R6", "data held", data_o, w);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "conv_o",  {15'd0, conv_o},  16'd0);
        cmp("R1", "sclk_o",  {15'd0, sclk_o},  16'd0);
        cmp("R1", "busy_o",  {15'd0, busy_o},  16'd0);
        cmp("R1", "valid_o", {15'd0, valid_o}, 16'd0);
        cmp("R1", "data_o",  data_o,           16'd0);
        rst_n = 1;
        @(negedge clk);
        cmp("R1", "conv_o after release", {15'd0, conv_o}, 16'd0);

        run_word(16'h0000, 16'd5,  "R8", 0);
        run_word(16'hFFFF, 16'd1,  "R8", 0);
        run_word(16'hA5C3, 16'd0,  "R5", 0);
        run_word(16'h8001, 16'd20, "R5", 0);
        run_word(16'h3C96, 16'd7,  "R7", 1);

        // R9: start held across completion
        cv_word = 16'h1234;
        @(negedge clk);
        start_i = 1; conv_cycles_i = 16'd4;
        @(negedge clk);
        wait_valid();
        cmp("R9", "first word", data_o, 16'h1234);
        cv_word = 16'h5A0F;
        @(negedge clk);
        cmp("R9", "restart busy", {15'd0, busy_o}, 16'd1);
        cmp("R9", "restart conv", {15'd0, conv_o}, 16'd1);
        start_i = 0;
        rises = 0;
        wait_valid();
        cmp("R9", "second word", data_o, 16'h5A0F);
        cmp("R4", "second sclk rises", 16'(rises), 16'd16);

        repeat (4) @(negedge clk);
        finished = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end
endmodule